// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between the slave side of a two-wire serial memory interface and its non-volatile array. Once the bus engine has decoded a write control byte and a word address, it pulses `wr_start` with that address. Each received data byte then arrives with a `byte_vld` strobe and is kept in a small page latch. Only the low in-page bits of the pointer advance, so a long burst wraps and overwrites the oldest slots. The page bits of the address stay fixed for the whole transaction.

When the bus engine reports a STOP and at least one byte has been latched, the block starts a self-timed programming cycle. It raises `busy` for exactly `WRITE_CYCLES` system clocks, and the bus engine uses that flag to withhold acknowledges. At the start of that window the block scans the page slots in ascending order and issues one array write per cycle, but only for slots loaded in this transaction. A write-protect input that is high at STOP cancels programming, so the whole memory behaves as read-only.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: The first data byte goes to the slot given by the low 4 bits of `wr_base`, and each further byte goes to the next slot. At commit, slot s is written to address {`wr_base[10:4]`, s} with the byte last latched there.
- R3: When more than 16 bytes arrive, the slot pointer wraps from 15 to 0 and later bytes replace earlier ones. The upper 7 address bits never change within a transaction.
- R4: During commit, `mem_we` is high only for loaded slots, at most once per slot. Slot s is written in the s-th cycle after the STOP edge, where cycle 0 is the first cycle after that edge, and one byte is written per cycle.
- R5: A STOP with no data byte latched, whether after `wr_start` alone or with no open transaction, starts no cycle: `busy` stays low and nothing is written.
- R6: A commit holds `busy` high for exactly `WRITE_CYCLES` consecutive cycles, starting in the first cycle after the STOP edge.
- R7: While `busy` is high, `wr_start`, `byte_vld` and `stop_in` are ignored. The committed data is unchanged and the next transaction starts from an empty buffer.
- R8: If `wp_in` is high together with STOP, no programming occurs: `busy` stays low, nothing is written and the latched bytes are discarded.
- R9: A `wr_start` during an open transaction discards all bytes latched so far and restarts at the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: write transaction opened, base address valid |
| wr_base | input | 11 | Start address: page bits [10:4], slot bits [3:0] |
| byte_vld | input | 1 | Pulse: one received data byte on `byte_data` |
| byte_data | input | 8 | Received data byte |
| stop_in | input | 1 | Pulse: STOP seen on the bus |
| wp_in | input | 1 | Write protect, sampled with STOP |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe, one byte per cycle |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The commit path is driven with single bytes, exactly full pages from an unaligned base, and bursts of 17 to 24 bytes. These patterns separate correct slot advance from a pointer that carries into the page bits or fails to overwrite in arrival order. Degenerate STOPs cover an empty transaction, a STOP with no open transaction, a protected STOP and a restarted transaction; they show whether the load mask and the commit condition are tracked apart from the data. Random transactions also inject starts, bytes and STOPs while `busy` is high, so any state that leaks across the write window shows up as a wrong byte or a wrong `busy` length.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwb_page_latch.sv
`timescale 1ns/1ps
// Page latch: one data register and one load flag per slot.
module pwb_page_latch #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int SLOT_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);
    logic [PAGE_BYTES-1:0] ld_vec;
    logic [DATA_W-1:0]     dat_arr [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] dat_d, dat_q;
        logic              ld_d, ld_q;

        always_comb begin
            dat_d = dat_q;
            ld_d  = ld_q;
            if (clr) begin
                ld_d = 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                dat_d = wr_data;
                ld_d  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dat_q <= '0;
                ld_q  <= 1'b0;
            end else begin
                dat_q <= dat_d;
                ld_q  <= ld_d;
            end
        end

        assign ld_vec[g]  = ld_q;
        assign dat_arr[g] = dat_q;
    end

    assign rd_data    = dat_arr[rd_slot];
    assign rd_loaded  = ld_vec[rd_slot];
    assign any_loaded = |ld_vec;
endmodule

// File: rtl/pwb_prog_timer.sv
`timescale 1ns/1ps
// Self-timed programming window counter.
module pwb_prog_timer #(
    parameter int CYCLES = 2000000,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    localparam logic [CNT_W-1:0] END_VAL = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else if (t_q.run) begin
            if (t_q.cnt == END_VAL) begin
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign count = t_q.cnt;
    assign last  = t_q.run && (t_q.cnt == END_VAL);
endmodule

// File: rtl/page_commit_ctrl.sv
`timescale 1ns/1ps
// Page write buffer with STOP-triggered, self-timed commit.
module page_commit_ctrl
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_in,
    input  logic              wp_in,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W:0] SCAN_END = (CNT_W + 1)'(PAGE_BYTES);

    typedef struct packed {
        pw_state_e         state;
        logic [PAGE_W-1:0] page;
        logic [SLOT_W-1:0] ptr;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              lat_clr, lat_wr;
    logic              tmr_start, tmr_last;
    logic [CNT_W-1:0]  tmr_count;
    logic [SLOT_W-1:0] scan_slot;
    logic [DATA_W-1:0] scan_data;
    logic              scan_loaded, any_loaded, in_scan;

    // Priority inside an open transaction: restart, then STOP, then data byte.
    always_comb begin
        r_d       = r_q;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (r_q.state)
            PW_IDLE: begin
                if (wr_start) begin
                    r_d.state = PW_FILL;
                    r_d.page  = wr_base[ADDR_W-1:SLOT_W];
                    r_d.ptr   = wr_base[SLOT_W-1:0];
                    lat_clr   = 1'b1;
                end
            end
            PW_FILL: begin
                if (wr_start) begin
                    r_d.page = wr_base[ADDR_W-1:SLOT_W];
                    r_d.ptr  = wr_base[SLOT_W-1:0];
                    lat_clr  = 1'b1;
                end else if (stop_in) begin
                    if (any_loaded && !wp_in) begin
                        r_d.state = PW_PROG;
                        tmr_start = 1'b1;
                    end else begin
                        r_d.state = PW_IDLE;
                        lat_clr   = 1'b1;
                    end
                end else if (byte_vld) begin
                    lat_wr  = 1'b1;
                    r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            PW_PROG: begin
                if (tmr_last) begin
                    r_d.state = PW_IDLE;
                    lat_clr   = 1'b1;
                end
            end
            default: r_d.state = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= PW_IDLE;
            r_q.page  <= '0;
            r_q.ptr   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    pwb_page_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .SLOT_W     (SLOT_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (lat_clr),
        .wr_en      (lat_wr),
        .wr_slot    (r_q.ptr),
        .wr_data    (byte_data),
        .rd_slot    (scan_slot),
        .rd_data    (scan_data),
        .rd_loaded  (scan_loaded),
        .any_loaded (any_loaded)
    );

    pwb_prog_timer #(
        .CYCLES (WRITE_CYCLES),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .count (tmr_count),
        .last  (tmr_last)
    );

    // The first PAGE_BYTES cycles of the window scan the slots in order.
    assign scan_slot = tmr_count[SLOT_W-1:0];
    assign in_scan   = {1'b0, tmr_count} < SCAN_END;
    assign busy      = (r_q.state == PW_PROG);
    assign mem_we    = busy && in_scan && scan_loaded;
    assign mem_addr  = {r_q.page, scan_slot};
    assign mem_wdata = scan_data;
endmodule

// File: rtl/page_commit_chk.sv
`timescale 1ns/1ps
module page_commit_chk #(
    parameter int PAGE_W       = 7,
    parameter int WRITE_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_in,
    input logic              wp_in,
    input logic              busy,
    input logic              mem_we,
    input logic [PAGE_W-1:0] page_bits
);
    logic [31:0] blen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 1;
        else           blen_q <= '0;
    end

    // R4
    we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3
    page_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_bits));

    // R5
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_in));

    // R8
    protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_in && wp_in) |=> !busy);

    // R6
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == 32'(WRITE_CYCLES)));
endmodule

bind page_commit_ctrl page_commit_chk #(
    .PAGE_W       (ADDR_W - $clog2(PAGE_BYTES)),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_in   (stop_in),
    .wp_in     (wp_in),
    .busy      (busy),
    .mem_we    (mem_we),
    .page_bits (mem_addr[ADDR_W-1:$clog2(PAGE_BYTES)])
);

// File: tb/tb_page_commit_ctrl.sv
`timescale 1ns/1ps
module tb_page_commit_ctrl;
    localparam int W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [10:0] wr_base = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_in = 1'b0;
    logic        wp_in = 1'b0;
    logic        busy, mem_we;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model of the requirements
    bit        m_in_txn = 0;
    bit [6:0]  m_page = '0;
    bit [3:0]  m_ptr = '0;
    bit [15:0] m_mask = '0;
    bit [7:0]  m_buf [16];

    always #2.5 clk = ~clk;

    page_commit_ctrl #(
        .ADDR_W(11), .DATA_W(8), .PAGE_BYTES(16), .WRITE_CYCLES(W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_base(wr_base),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_in(stop_in),
        .wp_in(wp_in), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_start(input logic [10:0] base);
        @(negedge clk);
        wr_start = 1'b1; wr_base = base;
        @(negedge clk);
        wr_start = 1'b0;
        m_in_txn = 1; m_page = base[10:4]; m_ptr = base[3:0]; m_mask = '0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
        if (m_in_txn) begin
            m_buf[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 4'd1;
        end
    endtask

    // Issue STOP, then observe the whole write window cycle by cycle.
    task automatic do_stop(input bit wp, input bit inject, input string req);
        bit exp_commit;
        int nwr = 0;
        @(negedge clk);
        stop_in = 1'b1; wp_in = wp;
        exp_commit = m_in_txn && (m_mask != 0) && !wp;
        @(negedge clk);
        stop_in = 1'b0; wp_in = 1'b0;
        for (int c = 0; c < W + 4; c++) begin
            bit exp_busy, exp_w;
            exp_busy = exp_commit && (c < W);
            check(busy == exp_busy, "R6", $sformatf("busy in cycle %0d", c), busy, exp_busy);
            exp_w = exp_commit && (c < 16) && m_mask[c[3:0]];
            check(mem_we == exp_w, req, $sformatf("mem_we in cycle %0d", c), mem_we, exp_w);
            if (mem_we && exp_w) begin
                nwr++;
                check(mem_addr == {m_page, c[3:0]}, req, "mem_addr", mem_addr, {m_page, c[3:0]});
                check(mem_wdata == m_buf[c[3:0]], req, "mem_wdata", mem_wdata, m_buf[c[3:0]]);
            end
            if (inject && busy) begin
                wr_start = $urandom_range(0, 1); wr_base = 11'($urandom);
                byte_vld = $urandom_range(0, 1); byte_data = 8'($urandom);
                stop_in = $urandom_range(0, 1);
            end else begin
                wr_start = 1'b0; byte_vld = 1'b0; stop_in = 1'b0;
            end
            @(negedge clk);
        end
        wr_start = 1'b0; byte_vld = 1'b0; stop_in = 1'b0;
        check(nwr == (exp_commit ? $countones(m_mask) : 0), req, "write count",
              nwr, exp_commit ? $countones(m_mask) : 0);
        m_in_txn = 0; m_mask = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);

        // R2: single byte write
        send_start(11'h2A7);
        send_byte(8'h5C);
        do_stop(0, 0, "R2");

        // R2: exactly one full page from an unaligned base
        send_start(11'h53B);
        for (int i = 0; i < 16; i++) send_byte(8'(8'h10 + i));
        do_stop(0, 0, "R2");

        // R3: 21 bytes wrap within the page
        send_start(11'h7FE);
        for (int i = 0; i < 21; i++) send_byte(8'(8'hA0 + i));
        do_stop(0, 0, "R3");

        // R5: STOP after start only, and STOP without any transaction
        send_start(11'h120);
        do_stop(0, 0, "R5");
        do_stop(0, 0, "R5");

        // R8: protected STOP discards the bytes
        send_start(11'h301);
        for (int i = 0; i < 5; i++) send_byte(8'($urandom));
        do_stop(1, 0, "R8");

        // R9: restart mid-transaction
        send_start(11'h444);
        for (int i = 0; i < 4; i++) send_byte(8'($urandom));
        send_start(11'h0CD);
        send_byte(8'h3E);
        send_byte(8'h9F);
        do_stop(0, 0, "R9");

        // R7: traffic during the window, then a fresh transaction
        send_start(11'h6B2);
        for (int i = 0; i < 7; i++) send_byte(8'($urandom));
        do_stop(0, 1, "R7");
        send_start(11'h6B9);
        send_byte(8'h77);
        do_stop(0, 0, "R7");

        // Random transactions: R2 R3 R4 R7 R8
        for (int t = 0; t < 30; t++) begin
            int nb;
            bit wp;
            nb = $urandom_range(0, 24);
            wp = ($urandom_range(0, 5) == 0);
            send_start(11'($urandom));
            for (int i = 0; i < nb; i++) send_byte(8'($urandom));
            do_stop(wp, bit'($urandom_range(0, 1)), "R4");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule